// File: doc/BRIEF.md
# Joinable Lane FIFO Pair

This block holds the two data queues that sit between the system bus and one execution lane. The transmit queue is filled by system writes and drained by the lane's engine. The receive queue is filled by the engine and drained by system reads. Each queue has four 32-bit entries.

A join setting can give all eight entries to one direction. The other direction then has no capacity at all. Both queues report full, empty and fill level, and they drive two raw interrupt conditions.

Misuse is never an error on the data path. A write to a full queue or a read from an empty queue leaves the queue exactly as it was. An engine access that cannot complete leaves the queue exactly as it was. In each case the block only raises a sticky debug flag, which software clears by writing 1 to it. Engine accesses can be blocking, where the engine is told to stall and retry, or non-blocking, where the access completes at once and its data is dropped when the queue cannot take it.

Top module: `lane_fifo_pair`

## Requirements
- R1: After reset both queues are empty with level 0, all four debug flags are 0, `irq_tx_nfull` is 1 and `irq_rx_nempty` is 0.
- R2: In separate mode (`join_cfg` 2'b00 or 2'b11) each queue holds four words in first-in first-out order, and `*_full` rises when the level reaches 4.
- R3: A system write while the transmit queue is full is dropped. Level and contents are unchanged, and flag bit 0 (transmit overflow) is set on the next cycle.
- R4: A system read while the receive queue is empty leaves the level unchanged and sets flag bit 1 (receive underflow) on the next cycle.
- R5: A blocking engine pull while the transmit queue is empty raises `eng_stall` in the same cycle, returns no data and sets flag bit 2 (transmit stall). A non-blocking pull on an empty queue raises neither.
- R6: An engine push while the receive queue is full stores nothing and sets flag bit 3 (receive stall). `eng_stall` is raised only if the push was blocking.
- R7: Writing 1 to a bit of `dbg_clr` clears only that flag. A set event in the same cycle wins, so the flag stays 1.
- R8: `irq_rx_nempty` is 1 exactly when the receive queue is not empty. `irq_tx_nfull` is 1 exactly when the transmit queue is not full.
- R9: Setting `join_cfg` to 2'b01 gives the transmit queue eight words. Setting it to 2'b10 gives the receive queue eight words. The unused queue then reports full=1, empty=1 and level 0.
- R10: A change of the effective join setting empties both queues on the next edge. Every queue access issued in that cycle has no effect and sets no flag.
- R11: An accepted write and an accepted pull in the same cycle on the transmit queue leave its level unchanged and keep word order.
- R12: A word written to a queue appears at that queue's read data output in the cycle after the write. Read data is the queue head, available without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| join_cfg | input | 2 | 00/11 separate, 01 joined transmit, 10 joined receive |
| sys_tx_wr | input | 1 | System write strobe to the transmit queue |
| sys_tx_wdata | input | 32 | System write data |
| sys_rx_rd | input | 1 | System read strobe (pops the receive queue) |
| sys_rx_rdata | output | 32 | Receive queue head |
| eng_pull | input | 1 | Engine pull request from the transmit queue |
| eng_pull_blk | input | 1 | Pull is blocking |
| eng_pull_data | output | 32 | Transmit queue head |
| eng_pull_valid | output | 1 | Pull accepted this cycle |
| eng_push | input | 1 | Engine push request into the receive queue |
| eng_push_blk | input | 1 | Push is blocking |
| eng_push_data | input | 32 | Engine push data |
| eng_push_acc | output | 1 | Push accepted this cycle |
| eng_stall | output | 1 | A blocking engine access could not complete |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_level | output | 4 | Transmit fill level, 0 to 8 |
| rx_level | output | 4 | Receive fill level, 0 to 8 |
| irq_rx_nempty | output | 1 | Raw receive-not-empty condition |
| irq_tx_nfull | output | 1 | Raw transmit-not-full condition |
| dbg_clr | input | 4 | Write-1-to-clear strobes for the flags |
| dbg_flags | output | 4 | Sticky flags: 0 tx overflow, 1 rx underflow, 2 tx stall, 3 rx stall |

## Verification
Two pairs of events can fall in the same cycle. The first is a flag-raising event and a write-1 clear of the same flag. The bench provokes it by issuing a read on the empty receive queue while strobing that flag's clear bit, and it expects the flag to read 1 afterwards. The second is a system write and an engine pull on a partly filled transmit queue. The bench expects the level to hold, and its scoreboard confirms that the words leave in the order written.

// File: rtl/lane_fifo_pkg.sv
// Shared types and flag bit positions for the lane FIFO pair.
package lane_fifo_pkg;

    // Effective storage arrangement after normalising the configuration input.
    typedef enum logic [1:0] {
        ARR_SPLIT = 2'b00,
        ARR_TX8   = 2'b01,
        ARR_RX8   = 2'b10
    } arrange_e;

    localparam int FLG_TX_OVER  = 0;
    localparam int FLG_RX_UNDER = 1;
    localparam int FLG_TX_STALL = 2;
    localparam int FLG_RX_STALL = 3;
    localparam int FLG_COUNT    = 4;

    // Map the raw two-bit setting onto an arrangement; 2'b11 counts as split.
    function automatic arrange_e decode_join(input logic [1:0] cfg);
        case (cfg)
            2'b01:   return ARR_TX8;
            2'b10:   return ARR_RX8;
            default: return ARR_SPLIT;
        endcase
    endfunction

endpackage

// File: rtl/lane_fifo_ctrl.sv
// Pointer and level bookkeeping for one queue inside a shared slot array.
// Assumes: cap is 0, DEPTH or 2*DEPTH and changes only together with flush;
// base + cap never exceeds the number of slots.
module lane_fifo_ctrl #(
    parameter int SLOTS = 8,
    parameter int IDX_W = $clog2(SLOTS),
    parameter int LVL_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [LVL_W-1:0] cap,
    input  logic [IDX_W-1:0] base,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);

    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] rd_ptr;
    logic [LVL_W-1:0] cnt;

    // Advance a pointer, wrapping at the current capacity.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p,
                                               input logic [LVL_W-1:0] c);
        if ((LVL_W'(p) + LVL_W'(1)) == c)
            return '0;
        else
            return p + IDX_W'(1);
    endfunction

    // Status and acceptance, all from the current state.
    always_comb begin
        full    = (cnt == cap);
        empty   = (cnt == '0);
        push_ok = push_req && !full && !flush;
        pop_ok  = pop_req && !empty && !flush;
        level   = cnt;
        wr_idx  = base + wr_ptr;
        rd_idx  = base + rd_ptr;
    end

    // Pointer and count update; flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= bump(wr_ptr, cap);
            if (pop_ok)
                rd_ptr <= bump(rd_ptr, cap);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + LVL_W'(1);
                2'b01:   cnt <= cnt - LVL_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/lane_fifo_store.sv
// Shared word storage with two write ports and two combinational read ports.
// Assumes: the two write ports never target the same slot in one cycle.
module lane_fifo_store #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 8,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_a,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [DATA_W-1:0] d_a,
    input  logic              we_b,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [DATA_W-1:0] d_b,
    input  logic [IDX_W-1:0]  ridx_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b
);

    logic [DATA_W-1:0] slot [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Capture a word into this slot from whichever port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (we_a && (idx_a == IDX_W'(i)))
                slot[i] <= d_a;
            else if (we_b && (idx_b == IDX_W'(i)))
                slot[i] <= d_b;
        end
    end

    // Head words for both queues.
    always_comb begin
        q_a = slot[ridx_a];
        q_b = slot[ridx_b];
    end

endmodule

// File: rtl/lane_fifo_flags.sv
// Sticky debug flags with write-1-to-clear; a set in the same cycle wins.
module lane_fifo_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] flags
);

    // Hold each flag until cleared, unless it is set again in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_v) | set_v;
    end

endmodule

// File: rtl/lane_fifo_pair.sv
// Transmit/receive queue pair for one execution lane, with optional joining
// of both storage halves into one direction. Misuse leaves queue state
// untouched and only raises sticky flags.
// Assumes: single clock; system and engine strobes are single-cycle requests.
module lane_fifo_pair
    import lane_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int SLOTS  = 2 * DEPTH,
    parameter int IDX_W  = $clog2(SLOTS),
    parameter int LVL_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        join_cfg,
    input  logic              sys_tx_wr,
    input  logic [DATA_W-1:0] sys_tx_wdata,
    input  logic              sys_rx_rd,
    output logic [DATA_W-1:0] sys_rx_rdata,
    input  logic              eng_pull,
    input  logic              eng_pull_blk,
    output logic [DATA_W-1:0] eng_pull_data,
    output logic              eng_pull_valid,
    input  logic              eng_push,
    input  logic              eng_push_blk,
    input  logic [DATA_W-1:0] eng_push_data,
    output logic              eng_push_acc,
    output logic              eng_stall,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic              irq_rx_nempty,
    output logic              irq_tx_nfull,
    input  logic [3:0]        dbg_clr,
    output logic [3:0]        dbg_flags
);

    localparam logic [LVL_W-1:0] CAP_HALF = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] CAP_ALL  = LVL_W'(SLOTS);
    localparam logic [IDX_W-1:0] RX_BASE  = IDX_W'(DEPTH);

    arrange_e          arr_q;
    arrange_e          arr_req;
    logic              flush;
    logic [LVL_W-1:0]  tx_cap, rx_cap;
    logic [IDX_W-1:0]  rx_base;
    logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [IDX_W-1:0]  tx_wr_idx, tx_rd_idx, rx_wr_idx, rx_rd_idx;
    logic [FLG_COUNT-1:0] flag_set;

    // Detect a change of arrangement; that cycle becomes a flush.
    always_comb begin
        arr_req = decode_join(join_cfg);
        flush   = (arr_req != arr_q);
    end

    // Remember the arrangement in force.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arr_q <= ARR_SPLIT;
        else
            arr_q <= arr_req;
    end

    // Split the slot array between the two queues.
    always_comb begin
        case (arr_q)
            ARR_TX8: begin
                tx_cap  = CAP_ALL;
                rx_cap  = '0;
                rx_base = '0;
            end
            ARR_RX8: begin
                tx_cap  = '0;
                rx_cap  = CAP_ALL;
                rx_base = '0;
            end
            default: begin
                tx_cap  = CAP_HALF;
                rx_cap  = CAP_HALF;
                rx_base = RX_BASE;
            end
        endcase
    end

    lane_fifo_ctrl #(.SLOTS(SLOTS), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_tx_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .cap      (tx_cap),
        .base     ('0),
        .push_req (sys_tx_wr),
        .pop_req  (eng_pull),
        .push_ok  (tx_push_ok),
        .pop_ok   (tx_pop_ok),
        .full     (tx_full),
        .empty    (tx_empty),
        .level    (tx_level),
        .wr_idx   (tx_wr_idx),
        .rd_idx   (tx_rd_idx)
    );

    lane_fifo_ctrl #(.SLOTS(SLOTS), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_rx_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .cap      (rx_cap),
        .base     (rx_base),
        .push_req (eng_push),
        .pop_req  (sys_rx_rd),
        .push_ok  (rx_push_ok),
        .pop_ok   (rx_pop_ok),
        .full     (rx_full),
        .empty    (rx_empty),
        .level    (rx_level),
        .wr_idx   (rx_wr_idx),
        .rd_idx   (rx_rd_idx)
    );

    lane_fifo_store #(.DATA_W(DATA_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_a   (tx_push_ok),
        .idx_a  (tx_wr_idx),
        .d_a    (sys_tx_wdata),
        .we_b   (rx_push_ok),
        .idx_b  (rx_wr_idx),
        .d_b    (eng_push_data),
        .ridx_a (tx_rd_idx),
        .ridx_b (rx_rd_idx),
        .q_a    (eng_pull_data),
        .q_b    (sys_rx_rdata)
    );

    // Engine handshake and raw interrupt conditions.
    always_comb begin
        eng_pull_valid = tx_pop_ok;
        eng_push_acc   = rx_push_ok;
        eng_stall      = (eng_pull && eng_pull_blk && !tx_pop_ok)
                       || (eng_push && eng_push_blk && !rx_push_ok);
        irq_rx_nempty  = !rx_empty;
        irq_tx_nfull   = !tx_full;
    end

    // Misuse events that feed the sticky flags; none fire during a flush.
    always_comb begin
        flag_set               = '0;
        flag_set[FLG_TX_OVER]  = sys_tx_wr && tx_full && !flush;
        flag_set[FLG_RX_UNDER] = sys_rx_rd && rx_empty && !flush;
        flag_set[FLG_TX_STALL] = eng_pull && eng_pull_blk && tx_empty && !flush;
        flag_set[FLG_RX_STALL] = eng_push && rx_full && !flush;
    end

    lane_fifo_flags #(.N(FLG_COUNT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (flag_set),
        .clr_v (dbg_clr),
        .flags (dbg_flags)
    );

    // rx_pop_ok is used only through the controller; keep it visible here.
    logic unused_rx_pop;
    assign unused_rx_pop = rx_pop_ok;

endmodule

// File: rtl/lane_fifo_chk.sv
// Temporal checks on the lane FIFO pair, attached by bind.
module lane_fifo_chk #(
    parameter int LVL_W = 4,
    parameter int SLOTS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             sys_tx_wr,
    input logic             sys_rx_rd,
    input logic             eng_pull,
    input logic             eng_pull_blk,
    input logic             eng_pull_valid,
    input logic             eng_push,
    input logic             tx_full,
    input logic             tx_empty,
    input logic             rx_full,
    input logic             rx_empty,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [3:0]       dbg_clr,
    input logic [3:0]       dbg_flags
);

    AST_TX_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tx_wr && tx_full && !flush |=> dbg_flags[0]); // R3
    AST_TX_OVER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tx_wr && tx_full && !eng_pull && !flush |=> $stable(tx_level)); // R3
    AST_RX_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rx_rd && rx_empty && !eng_push && !flush |=> dbg_flags[1] && $stable(rx_level)); // R4
    AST_TX_STALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_pull && eng_pull_blk && tx_empty && !flush |=> dbg_flags[2]); // R5
    AST_RX_STALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_push && rx_full && !flush |=> dbg_flags[3]); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_flags[3] && !dbg_clr[3] |=> dbg_flags[3]); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> tx_level == '0 && rx_level == '0); // R10
    AST_PUSHPOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        eng_pull_valid && sys_tx_wr && !tx_full |=> $stable(tx_level)); // R11
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(SLOTS) && rx_level <= LVL_W'(SLOTS)); // R9

endmodule

bind lane_fifo_pair lane_fifo_chk #(.LVL_W(LVL_W), .SLOTS(SLOTS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .sys_tx_wr      (sys_tx_wr),
    .sys_rx_rd      (sys_rx_rd),
    .eng_pull       (eng_pull),
    .eng_pull_blk   (eng_pull_blk),
    .eng_pull_valid (eng_pull_valid),
    .eng_push       (eng_push),
    .tx_full        (tx_full),
    .tx_empty       (tx_empty),
    .rx_full        (rx_full),
    .rx_empty       (rx_empty),
    .tx_level       (tx_level),
    .rx_level       (rx_level),
    .dbg_clr        (dbg_clr),
    .dbg_flags      (dbg_flags)
);

// File: tb/sim_lane_fifo_pair.sv
// Scoreboard bench: driver tasks queue expected words, a monitor compares them.
module sim_lane_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  join_cfg;
    logic        sys_tx_wr, sys_rx_rd, eng_pull, eng_pull_blk, eng_push, eng_push_blk;
    logic [31:0] sys_tx_wdata, eng_push_data, sys_rx_rdata, eng_pull_data;
    logic        eng_pull_valid, eng_push_acc, eng_stall;
    logic        tx_full, tx_empty, rx_full, rx_empty, irq_rx_nempty, irq_tx_nfull;
    logic [3:0]  tx_level, rx_level, dbg_clr, dbg_flags;

    int n_chk = 0;
    int n_err = 0;
    int cap_tx = 4;
    int cap_rx = 4;
    logic [31:0] tx_exp[$];
    logic [31:0] rx_exp[$];

    always #10 clk = ~clk;

    lane_fifo_pair u0 (
        .clk(clk), .rst_n(rst_n), .join_cfg(join_cfg),
        .sys_tx_wr(sys_tx_wr), .sys_tx_wdata(sys_tx_wdata),
        .sys_rx_rd(sys_rx_rd), .sys_rx_rdata(sys_rx_rdata),
        .eng_pull(eng_pull), .eng_pull_blk(eng_pull_blk),
        .eng_pull_data(eng_pull_data), .eng_pull_valid(eng_pull_valid),
        .eng_push(eng_push), .eng_push_blk(eng_push_blk),
        .eng_push_data(eng_push_data), .eng_push_acc(eng_push_acc),
        .eng_stall(eng_stall), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .tx_level(tx_level),
        .rx_level(rx_level), .irq_rx_nempty(irq_rx_nempty),
        .irq_tx_nfull(irq_tx_nfull), .dbg_clr(dbg_clr), .dbg_flags(dbg_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle;
        sys_tx_wr = 0; sys_rx_rd = 0; eng_pull = 0; eng_pull_blk = 0;
        eng_push = 0; eng_push_blk = 0; dbg_clr = '0;
    endtask

    // Wait for the edge, then release all strobes.
    task automatic tick;
        @(posedge clk);
        #2;
        idle();
    endtask

    task automatic sys_write(input logic [31:0] d);
        sys_tx_wr = 1; sys_tx_wdata = d;
        if (tx_exp.size() < cap_tx) tx_exp.push_back(d);
    endtask

    task automatic eng_write(input logic [31:0] d, input logic blk);
        eng_push = 1; eng_push_blk = blk; eng_push_data = d;
        if (rx_exp.size() < cap_rx) rx_exp.push_back(d);
    endtask

    task automatic pull(input logic blk);
        eng_pull = 1; eng_pull_blk = blk;
    endtask

    // Change the arrangement: a flush cycle that empties both model queues.
    task automatic set_join(input logic [1:0] cfg, input int ct, input int cr);
        join_cfg = cfg;
        tx_exp.delete(); rx_exp.delete();
        cap_tx = ct; cap_rx = cr;
        tick();
    endtask

    // Monitor: compare every word leaving either queue with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (eng_pull_valid) begin
                if (tx_exp.size() == 0) check("R2 unexpected pull", eng_pull_data, 32'hx);
                else check("R2/R11 pull order", eng_pull_data, tx_exp.pop_front());
            end
            if (sys_rx_rd && !rx_empty) begin
                if (rx_exp.size() == 0) check("R2 unexpected read", sys_rx_rdata, 32'hx);
                else check("R2 read order", sys_rx_rdata, rx_exp.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle(); join_cfg = 2'b00; sys_tx_wdata = '0; eng_push_data = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        // R1 reset state
        check("R1 levels", {24'd0, tx_level, rx_level}, 32'h0);
        check("R1 empty", {30'd0, tx_empty, rx_empty}, 32'h3);
        check("R1 flags", {28'd0, dbg_flags}, 32'h0);
        check("R1 irq", {30'd0, irq_tx_nfull, irq_rx_nempty}, 32'h2);

        // R2/R12 fill transmit queue
        sys_write(32'hA000_0000); tick();
        check("R12 head visible", eng_pull_data, 32'hA000_0000);
        for (int i = 1; i < 4; i++) begin sys_write(32'hA000_0000 + i); tick(); end
        check("R2 tx full level", {27'd0, tx_full, tx_level}, {27'd0, 1'b1, 4'd4});
        check("R8 tx not-full irq low", {31'd0, irq_tx_nfull}, 32'h0);

        // R3 overflow
        sys_write(32'hDEAD_BEEF); tick();
        check("R3 level kept", {28'd0, tx_level}, 32'd4);
        check("R3 overflow flag", {31'd0, dbg_flags[0]}, 32'h1);
        for (int i = 0; i < 4; i++) begin pull(0); tick(); end
        check("R3 contents intact", {31'd0, tx_empty}, 32'h1);
        check("R3 all words seen", tx_exp.size(), 32'd0);

        // R5 blocking and non-blocking pull on empty
        dbg_clr = 4'hF; tick();
        pull(1); #1;
        check("R5 stall blocking", {30'd0, eng_stall, eng_pull_valid}, 32'h2);
        tick();
        check("R5 tx stall flag", {31'd0, dbg_flags[2]}, 32'h1);
        dbg_clr = 4'hF; tick();
        pull(0); #1;
        check("R5 no stall nonblocking", {31'd0, eng_stall}, 32'h0);
        tick();
        check("R5 no flag nonblocking", {31'd0, dbg_flags[2]}, 32'h0);

        // R6 push on full receive queue
        for (int i = 0; i < 4; i++) begin eng_write(32'hB000_0000 + i, 1); tick(); end
        check("R6 rx full level", {27'd0, rx_full, rx_level}, {27'd0, 1'b1, 4'd4});
        check("R8 rx not-empty irq", {31'd0, irq_rx_nempty}, 32'h1);
        eng_write(32'hBAD0_0001, 1); #1;
        check("R6 blocking stall", {30'd0, eng_stall, eng_push_acc}, 32'h2);
        tick();
        check("R6 rx stall flag", {27'd0, dbg_flags[3], rx_level}, {27'd0, 1'b1, 4'd4});
        dbg_clr = 4'hF; tick();
        eng_write(32'hBAD0_0002, 0); #1;
        check("R6 nonblocking no stall", {31'd0, eng_stall}, 32'h0);
        tick();
        check("R6 nonblocking drop flag", {27'd0, dbg_flags[3], rx_level}, {27'd0, 1'b1, 4'd4});
        for (int i = 0; i < 4; i++) begin sys_rx_rd = 1; tick(); end
        check("R6 rx drained", {31'd0, rx_empty}, 32'h1);

        // R4 underflow
        sys_rx_rd = 1; tick();
        check("R4 underflow", {27'd0, dbg_flags[1], rx_level}, {27'd0, 1'b1, 4'd0});

        // R7 selective clear and set-wins
        dbg_clr = 4'b0010; tick();
        check("R7 selective clear", {28'd0, dbg_flags}, 32'h8);
        sys_rx_rd = 1; dbg_clr = 4'b0010; tick();
        check("R7 set beats clear", {31'd0, dbg_flags[1]}, 32'h1);
        dbg_clr = 4'hF; tick();
        check("R7 all cleared", {28'd0, dbg_flags}, 32'h0);

        // R11 simultaneous write and pull
        sys_write(32'hC000_0000); tick();
        sys_write(32'hC000_0001); tick();
        sys_write(32'hC000_0002); pull(0); tick();
        check("R11 level held", {28'd0, tx_level}, 32'd2);
        pull(0); tick(); pull(0); tick();
        check("R11 order drained", tx_exp.size(), 32'd0);

        // R9 joined transmit
        set_join(2'b01, 8, 0);
        check("R9 rx zero capacity", {26'd0, rx_full, rx_empty, rx_level}, {26'd0, 2'b11, 4'd0});
        for (int i = 0; i < 8; i++) begin sys_write(32'hD000_0000 + i); tick(); end
        check("R9 tx eight deep", {27'd0, tx_full, tx_level}, {27'd0, 1'b1, 4'd8});
        eng_write(32'hEEEE_0000, 0); tick();
        check("R9 rx push stalls", {31'd0, dbg_flags[3]}, 32'h1);
        for (int i = 0; i < 5; i++) begin pull(0); tick(); end
        dbg_clr = 4'hF; tick();

        // R10 change flushes, same-cycle write dropped
        check("R10 pre-flush level", {28'd0, tx_level}, 32'd3);
        sys_write(32'hF000_0000);
        set_join(2'b10, 0, 8);
        check("R10 flushed", {24'd0, tx_level, rx_level}, 32'h0);
        check("R10 no flag", {28'd0, dbg_flags}, 32'h0);
        check("R9 tx zero capacity", {30'd0, tx_full, tx_empty}, 32'h3);

        // R9 joined receive
        for (int i = 0; i < 8; i++) begin eng_write(32'h7000_0000 + i, 1); tick(); end
        check("R9 rx eight deep", {27'd0, rx_full, rx_level}, {27'd0, 1'b1, 4'd8});
        for (int i = 0; i < 8; i++) begin sys_rx_rd = 1; tick(); end
        check("R9 rx order drained", rx_exp.size(), 32'd0);

        // R2 setting 11 is split
        set_join(2'b00, 4, 4);
        sys_write(32'h1234_5678); tick();
        join_cfg = 2'b11; tick();
        check("R2 cfg 11 no flush", {28'd0, tx_level}, 32'd1);
        pull(0); tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule